// File: doc/BRIEF.md
# DDR Read Strobe and Burst Sequencer

This block is the read-side output sequencer of a DDR memory device model. It takes a read command with a start column, a burst length code, a burst order and a CAS latency code. It then schedules the data beats of that burst: for each beat it gives the column to fetch, the data output enable, the strobe level and the strobe drive enable. The block runs on an internal clock at twice the memory clock rate, so one internal cycle is half a memory clock. This lets a latency of 2.5 clocks, a one-clock preamble and a half-clock postamble all be expressed in whole cycles.

Each burst puts one word on every strobe edge. The strobe rises together with the first word and falls together with the second, so it is edge-aligned with the data. A read that arrives while another burst is still in flight is held in a single pending slot. If it is timed so that its data directly follows the current burst, the strobe continues without a gap and without any low period. A read that arrives while the pending slot is already taken is dropped and raises a sticky error flag.

The control is one state machine. Its states are IDLE (nothing driven), WAIT (a read is counting down, strobe undriven), PRE (strobe driven low ahead of data), BURST (one beat per cycle) and POST (strobe driven low after data). The transitions are:
- IDLE or POST to WAIT, PRE or BURST when the pending read is taken over, picked by how many half-cycles remain before its first beat.
- POST to IDLE when nothing is pending.
- WAIT to PRE two half-cycles before the first beat.
- PRE to BURST at the first beat.
- BURST to BURST for the next beat, or for a pending read that is due at once.
- BURST to POST after the last beat.

Top module: `ddr_rd_seq`

## Requirements
- R1: While `rst` is high, and after reset until a read is accepted, `dq_oe`, `dqs_oe`, `dqs` and `rd_err` are all low.
- R2: A read sampled on edge t shows its first beat on the outputs after edge t+L, where L is in half-cycles: `rd_cl` code 0 gives 4 (latency 2), code 1 gives 5 (latency 2.5), and codes 2 and 3 give 6 (latency 3).
- R3: `dq_oe` stays high for exactly N consecutive half-cycles per burst: `rd_bl` code 0 gives N=2, code 1 gives N=4, and codes 2 and 3 give N=8.
- R4: With `rd_bt`=0 (sequential), beat k outputs the column whose low log2(N) bits are (s+k) mod N, where s is the start column's low bits. The upper column bits are kept from the start column.
- R5: With `rd_bt`=1 (interleaved), beat k outputs the column whose low log2(N) bits are s XOR k. The upper bits are kept.
- R6: During data, `dqs` is high on even beats and low on odd beats, so each word sits on its own strobe edge.
- R7: For the two half-cycles before a first beat, `dqs_oe` is high and `dqs` is low.
- R8: For the one half-cycle after the last beat, `dqs_oe` is high and `dqs` is low; after that `dqs_oe` falls unless another read's preamble or data begins.
- R9: A second read sampled so that its first beat lands right after the first burst's last beat gives continuous `dq_oe`, with `dqs` toggling at every beat across the seam.
- R10: When the idle span between two bursts is 1 to 3 half-cycles, `dqs_oe` stays high and `dqs` low through the whole span. With a span of 4 or more, the strobe is released in between.
- R11: A read arriving while the pending slot is full, and is not being taken over in that same cycle, is dropped and sets `rd_err` from the next edge until reset. The bursts already held are not disturbed.
- R12: `dq_oe` is never high while `dqs_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read command strobe, one cycle |
| rd_col | input | COL_W | Start column of the read |
| rd_bl | input | 2 | Burst length code (0:2, 1:4, 2/3:8) |
| rd_bt | input | 1 | Burst order: 0 sequential, 1 interleaved |
| rd_cl | input | 2 | Latency code (0:2, 1:2.5, 2/3:3 clocks) |
| dq_oe | output | 1 | Data output enable, one beat per cycle |
| dqs_oe | output | 1 | Strobe drive enable |
| dqs | output | 1 | Strobe level while driven |
| beat_col | output | COL_W | Column of the beat on the pins |
| rd_err | output | 1 | Sticky flag: a read was dropped |

## Verification
The bench builds the block with its default 8-bit column. This leaves room for start columns whose upper bits differ from their low burst offset, so wrap-around within the aligned block is visible for every burst length. Random reads are spaced only as legal timing allows. With all latency and length codes mixed, this naturally hits merged bursts, short gaps and long gaps between strobe windows. Directed cases add exact seams, gaps of one to four half-cycles, the reserved codes and an overflowing third read.

// File: rtl/ddr_rdseq_pkg.sv
package ddr_rdseq_pkg;

    localparam int MAX_BL  = 8;
    localparam int MAX_LAT = 6;
    localparam int BEAT_W  = $clog2(MAX_BL);
    localparam int LEN_W   = BEAT_W + 1;
    localparam int REM_W   = $clog2(MAX_LAT + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_BURST,
        ST_POST
    } seq_state_t;

    // latency code to half-cycles before the first beat
    function automatic logic [REM_W-1:0] lat_half(input logic [1:0] code);
        unique case (code)
            2'd0:    lat_half = REM_W'(4);
            2'd1:    lat_half = REM_W'(5);
            default: lat_half = REM_W'(6);
        endcase
    endfunction

    // burst code to beat count
    function automatic logic [LEN_W-1:0] burst_beats(input logic [1:0] code);
        unique case (code)
            2'd0:    burst_beats = LEN_W'(2);
            2'd1:    burst_beats = LEN_W'(4);
            default: burst_beats = LEN_W'(8);
        endcase
    endfunction

    // state entered when a read with r half-cycles left is taken over
    function automatic seq_state_t entry_state(input logic [REM_W-1:0] r);
        if (r == '0)
            entry_state = ST_BURST;
        else if (r <= REM_W'(2))
            entry_state = ST_PRE;
        else
            entry_state = ST_WAIT;
    endfunction

endpackage

// File: rtl/rdseq_queue.sv
module rdseq_queue
    import ddr_rdseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_vld,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       cmd_bl,
    input  logic             cmd_bt,
    input  logic [1:0]       cmd_cl,
    input  logic             promote,
    output logic             q_vld,
    output logic [REM_W-1:0] q_rem_nxt,
    output logic [COL_W-1:0] q_col,
    output logic [LEN_W-1:0] q_len,
    output logic             q_bt,
    output logic             err
);

    logic [REM_W-1:0] q_rem;
    logic             accept;
    logic             overflow;

    assign accept    = cmd_vld && (!q_vld || promote);
    assign overflow  = cmd_vld && q_vld && !promote;
    assign q_rem_nxt = (q_rem == '0) ? '0 : q_rem - REM_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld <= 1'b0;
            q_rem <= '0;
            q_col <= '0;
            q_len <= '0;
            q_bt  <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (accept) begin
                q_vld <= 1'b1;
                q_rem <= lat_half(cmd_cl);
                q_col <= cmd_col;
                q_len <= burst_beats(cmd_bl);
                q_bt  <= cmd_bt;
            end else if (promote) begin
                q_vld <= 1'b0;
            end else if (q_vld) begin
                q_rem <= q_rem_nxt;
            end
            if (overflow)
                err <= 1'b1;
        end
    end

    // R11
    overflow_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> err);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R11
    free_slot_takes_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && !q_vld) |=> q_vld);

endmodule

// File: rtl/rdseq_colgen.sv
module rdseq_colgen
    import ddr_rdseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [LEN_W-1:0]  len,
    input  logic              interleave,
    input  logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0]  col
);

    logic [BEAT_W-1:0] off_seq;
    logic [BEAT_W-1:0] off_ilv;
    logic [BEAT_W-1:0] off;
    logic [COL_W-1:0]  mask;

    always_comb begin
        off_seq = base_col[BEAT_W-1:0] + beat;
        off_ilv = base_col[BEAT_W-1:0] ^ beat;
        off     = interleave ? off_ilv : off_seq;
        mask    = COL_W'(len - LEN_W'(1));
        col     = (base_col & ~mask) | (COL_W'(off) & mask);
    end

endmodule

// File: rtl/rdseq_fsm.sv
module rdseq_fsm
    import ddr_rdseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_vld,
    input  logic [REM_W-1:0]  q_rem_nxt,
    input  logic [COL_W-1:0]  q_col,
    input  logic [LEN_W-1:0]  q_len,
    input  logic              q_bt,
    output logic              promote,
    output logic [COL_W-1:0]  a_col,
    output logic [LEN_W-1:0]  a_len,
    output logic              a_bt,
    output logic [BEAT_W-1:0] beat,
    output logic              dq_oe,
    output logic              dqs_oe,
    output logic              dqs
);

    seq_state_t       state;
    seq_state_t       nxt;
    logic [REM_W-1:0] a_rem;
    logic [REM_W-1:0] rem_dec;
    logic             last;
    logic             q_due;

    assign rem_dec = (a_rem == '0) ? '0 : a_rem - REM_W'(1);
    assign last    = (state == ST_BURST) && ({1'b0, beat} == a_len - LEN_W'(1));
    assign q_due   = q_vld && (q_rem_nxt == '0);

    // next state and take-over decision
    always_comb begin
        nxt     = state;
        promote = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (q_vld) begin
                    promote = 1'b1;
                    nxt     = entry_state(q_rem_nxt);
                end
            end
            ST_WAIT: begin
                if (rem_dec <= REM_W'(2))
                    nxt = ST_PRE;
            end
            ST_PRE: begin
                if (rem_dec == '0)
                    nxt = ST_BURST;
            end
            ST_BURST: begin
                if (last) begin
                    if (q_due) begin
                        promote = 1'b1;
                        nxt     = ST_BURST;
                    end else begin
                        nxt = ST_POST;
                    end
                end
            end
            ST_POST: begin
                if (q_vld) begin
                    promote = 1'b1;
                    nxt     = entry_state(q_rem_nxt);
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and active-burst context
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            a_rem <= '0;
            beat  <= '0;
            a_col <= '0;
            a_len <= '0;
            a_bt  <= 1'b0;
        end else begin
            state <= nxt;
            if (promote) begin
                a_rem <= q_rem_nxt;
                a_col <= q_col;
                a_len <= q_len;
                a_bt  <= q_bt;
                beat  <= '0;
            end else begin
                if (state == ST_WAIT || state == ST_PRE)
                    a_rem <= rem_dec;
                if (state == ST_BURST && !last)
                    beat <= beat + BEAT_W'(1);
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        dq_oe  = 1'b0;
        dqs_oe = 1'b0;
        dqs    = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT: ;
            ST_PRE, ST_POST: dqs_oe = 1'b1;
            ST_BURST: begin
                dq_oe  = 1'b1;
                dqs_oe = 1'b1;
                dqs    = ~beat[0];
            end
            default: ;
        endcase
    end

    // R7
    preamble_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> ($past(dqs_oe) && !$past(dqs) && $past(dqs_oe, 2) && !$past(dqs, 2)));

    // R8
    postamble_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> (dqs_oe && !dqs));

    // R8
    release_after_post_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dqs_oe) |-> ($past(state) == ST_POST));

    // R6
    strobe_toggles_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> (dqs != $past(dqs)));

    // R3
    burst_ends_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> ({1'b0, $past(beat)} == $past(a_len) - LEN_W'(1)));

endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
    import ddr_rdseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] rd_col,
    input  logic [1:0]       rd_bl,
    input  logic             rd_bt,
    input  logic [1:0]       rd_cl,
    output logic             dq_oe,
    output logic             dqs_oe,
    output logic             dqs,
    output logic [COL_W-1:0] beat_col,
    output logic             rd_err
);

    logic              q_vld;
    logic [REM_W-1:0]  q_rem_nxt;
    logic [COL_W-1:0]  q_col;
    logic [LEN_W-1:0]  q_len;
    logic              q_bt;
    logic              promote;
    logic [COL_W-1:0]  a_col;
    logic [LEN_W-1:0]  a_len;
    logic              a_bt;
    logic [BEAT_W-1:0] beat;

    rdseq_queue #(.COL_W(COL_W)) i_queue (
        .clk       (clk),
        .rst       (rst),
        .cmd_vld   (rd_cmd),
        .cmd_col   (rd_col),
        .cmd_bl    (rd_bl),
        .cmd_bt    (rd_bt),
        .cmd_cl    (rd_cl),
        .promote   (promote),
        .q_vld     (q_vld),
        .q_rem_nxt (q_rem_nxt),
        .q_col     (q_col),
        .q_len     (q_len),
        .q_bt      (q_bt),
        .err       (rd_err)
    );

    rdseq_fsm #(.COL_W(COL_W)) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .q_vld     (q_vld),
        .q_rem_nxt (q_rem_nxt),
        .q_col     (q_col),
        .q_len     (q_len),
        .q_bt      (q_bt),
        .promote   (promote),
        .a_col     (a_col),
        .a_len     (a_len),
        .a_bt      (a_bt),
        .beat      (beat),
        .dq_oe     (dq_oe),
        .dqs_oe    (dqs_oe),
        .dqs       (dqs)
    );

    rdseq_colgen #(.COL_W(COL_W)) i_colgen (
        .base_col   (a_col),
        .len        (a_len),
        .interleave (a_bt),
        .beat       (beat),
        .col        (beat_col)
    );

    // R12
    data_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(dqs_oe));

endmodule

// File: tb/test_ddr_rd_seq.sv
module test_ddr_rd_seq;

    localparam int COL_W = 8;
    localparam int NT    = 4096;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_cmd = 1'b0;
    logic [COL_W-1:0] rd_col = '0;
    logic [1:0]       rd_bl = '0;
    logic             rd_bt = 1'b0;
    logic [1:0]       rd_cl = '0;
    logic             dq_oe, dqs_oe, dqs, rd_err;
    logic [COL_W-1:0] beat_col;

    ddr_rd_seq #(.COL_W(COL_W)) i_ddr_rd_seq (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .rd_col(rd_col), .rd_bl(rd_bl),
        .rd_bt(rd_bt), .rd_cl(rd_cl), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs(dqs),
        .beat_col(beat_col), .rd_err(rd_err)
    );

    always #5 clk = ~clk;

    int edge_cnt = 0;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    bit               exp_dq [NT];
    bit               exp_oe [NT];
    bit               exp_dqs[NT];
    bit               exp_b2b[NT];
    bit               exp_il [NT];
    logic [COL_W-1:0] exp_col[NT];
    int  err_edge = NT + 100;
    int  checks = 0;
    int  fails = 0;
    int  last_end = -1;
    int  fin_a = -1;
    int  fin_b = -1;
    bit  done = 1'b0;

    function automatic int lat_of(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 5 : 6;
    endfunction

    function automatic int len_of(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [COL_W-1:0] col_of(input int base, input bit il, input int n, input int k);
        int s = base % n;
        int off = il ? (s ^ k) : ((s + k) % n);
        return COL_W'(base - s + off);
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d at edge %0d", tag, what, act, exp, edge_cnt);
        end
    endtask

    task automatic compare_now();
        int i = edge_cnt;
        if (i >= NT) return;
        check(dq_oe == exp_dq[i], exp_b2b[i] ? "R9" : "R2,R3", "dq_oe", dq_oe, exp_dq[i]);
        check(dqs_oe == exp_oe[i], "R7,R8,R10", "dqs_oe", dqs_oe, exp_oe[i]);
        check(dqs == exp_dqs[i], "R6", "dqs", dqs, exp_dqs[i]);
        if (exp_dq[i])
            check(beat_col == exp_col[i], exp_il[i] ? "R5" : "R4", "beat_col", beat_col, exp_col[i]);
        check(rd_err == (i >= err_edge), "R11", "rd_err", rd_err, i >= err_edge);
        if (dq_oe)
            check(dqs_oe, "R12", "dqs_oe with data", dqs_oe, 1);
    endtask

    task automatic schedule(input int t, input logic [1:0] bl, input logic [1:0] cl,
                            input bit bt, input int col);
        int lat = lat_of(cl);
        int n = len_of(bl);
        int first = t + lat;
        bit seam = (first == last_end + 1);
        if (first + n + 1 >= NT) return;
        for (int k = 0; k < n; k++) begin
            exp_dq[first + k]  = 1'b1;
            exp_dqs[first + k] = (k % 2 == 0);
            exp_col[first + k] = col_of(col, bt, n, k);
            exp_il[first + k]  = bt;
        end
        for (int i = first - 2; i <= first + n; i++)
            exp_oe[i] = 1'b1;
        if (seam) begin
            exp_b2b[first] = 1'b1;
            exp_b2b[last_end] = 1'b1;
        end
        last_end = first + n - 1;
        fin_a = fin_b;
        fin_b = first + n + 1;
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        compare_now();
        rd_cmd = 1'b0;
    endtask

    task automatic drive(input logic [1:0] bl, input logic [1:0] cl, input bit bt,
                         input int col, input bit keep);
        rd_cmd = 1'b1;
        rd_bl  = bl;
        rd_cl  = cl;
        rd_bt  = bt;
        rd_col = COL_W'(col);
        if (keep) schedule(edge_cnt + 1, bl, cl, bt, col);
    endtask

    task automatic issue(input logic [1:0] bl, input logic [1:0] cl, input bit bt, input int col);
        begin_cycle();
        drive(bl, cl, bt, col, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin_cycle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!dq_oe && !dqs_oe && !dqs && !rd_err, "R1", "outputs in reset",
                  {dq_oe, dqs_oe, dqs, rd_err}, 0);
        end
        rst = 1'b0;
        idle(4);
        check(!dq_oe && !dqs_oe && !rd_err, "R1", "outputs after reset", {dq_oe, dqs_oe, rd_err}, 0);

        // constrained random reads
        for (int c = 0; c < 1500; c++) begin
            begin_cycle();
            if ($urandom % 3 == 0) begin
                logic [1:0] bl = 2'($urandom % 4);
                logic [1:0] cl = 2'($urandom % 4);
                bit bt = 1'($urandom % 2);
                int col = int'($urandom % 256);
                int t = edge_cnt + 1;
                int busy = ((fin_a > t) ? 1 : 0) + ((fin_b > t) ? 1 : 0);
                if (t + lat_of(cl) > last_end && busy <= 1)
                    drive(bl, cl, bt, col, 1'b1);
            end
        end
        idle(20);

        // R9 seam between two bursts of four at latency 2
        issue(2'd1, 2'd0, 1'b0, 8'h05);
        idle(3);
        issue(2'd1, 2'd0, 1'b1, 8'h0B);
        idle(16);

        // R10 gaps of one to four half-cycles between bursts of two
        for (int g = 1; g <= 4; g++) begin
            issue(2'd0, 2'd0, 1'b0, 8'h11 + g);
            idle(1 + g);
            issue(2'd0, 2'd0, 1'b1, 8'h21 + g);
            idle(14);
        end

        // R2 R5 latency 2.5 with interleaved eight, R4 latency 3 sequential eight
        issue(2'd2, 2'd1, 1'b1, 8'h35);
        idle(20);
        issue(2'd2, 2'd2, 1'b0, 8'h6E);
        idle(20);
        // reserved codes behave as the longest settings
        issue(2'd3, 2'd3, 1'b0, 8'hC7);
        idle(20);

        // R11 third read while the slot is full
        issue(2'd0, 2'd2, 1'b0, 8'h40);
        idle(1);
        issue(2'd0, 2'd2, 1'b0, 8'h52);
        begin_cycle();
        drive(2'd2, 2'd0, 1'b0, 8'h77, 1'b0);
        err_edge = edge_cnt + 1;
        idle(24);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule